// File: doc/BRIEF.md
# Serial Display Command Receiver

This block sits between a host controller and the scan logic of an LED matrix driver. The host talks to it over three wires: a strobe, a serial clock and a data line. All three are brought into a fast system clock domain through two-flop synchronisers. Rising serial-clock edges are detected there, and data bits are shifted in least significant bit first. A frame starts when the strobe falls. Its first complete byte is a command, and every later byte in the same frame is display data.

Commands fall into four classes, picked by the top two bits of the byte. A class can choose the grid/segment layout, set the data transfer attributes, load the memory pointer, or switch the display on or off and set its dimming. Data bytes go into a 14-byte display memory. After each write the pointer either moves up by one or stays where it is. A pointer beyond the last location blocks all writes until the host loads a valid address. The scan logic reads the configuration and the whole memory as plain parallel outputs. Key readout is handled by a separate port and is not part of this block.

Top module: `dsp_cmd_if`

## Requirements
- R1: A byte is assembled from eight rising edges of `sclk_i` taken while `stb_i` is low. The bit on `dio_i` at the first edge becomes bit 0 and the bit at the eighth edge becomes bit 7. `byte_stb_o` pulses for one system clock for each completed byte.
- R2: While `stb_i` is high, toggling `sclk_i` or `dio_i` leaves all outputs unchanged.
- R3: If `stb_i` rises before a byte is complete, the partial bits are discarded. The first byte after the next falling edge of `stb_i` is treated as a command.
- R4: A command's bits 7:6 select its class: 00 display mode, 01 data setting, 10 display control, 11 address setting. Bits 5:4 are ignored in every class.
- R5: In a display mode command, bits 1:0 = 00 select 4 grids by 8 segments (`grid5_o`=0) and 01 selects 5 grids by 7 segments (`grid5_o`=1). Other values and bits 5:2 have no effect. Re-sending the current layout changes nothing. A real change also clears `disp_on_o`.
- R6: A data setting command sets `test_mode_o` from bit 3, `fixed_addr_o` from bit 2 and `read_keys_o` from bit 1. Bits 1:0 = 00 means write-display and 10 means read-keys.
- R7: An address setting command loads bits 3:0 into `addr_o`. Data bytes are written only while `addr_o` is 0x00 to 0x0D. At 0x0E or 0x0F the bytes are dropped and the address does not move.
- R8: A data byte written while `fixed_addr_o`=0 advances `addr_o` by one, so a write at 0x0D leaves 0x0E. With `fixed_addr_o`=1 the address stays unchanged.
- R9: A display control command sets `disp_on_o` from bit 3 and `dim_o` from bits 2:0.
- R10: After reset, `addr_o`=0, `test_mode_o`=`fixed_addr_o`=`read_keys_o`=0, `disp_on_o`=0, `dim_o`=0, `grid5_o`=0 and all memory bytes are 0.
- R11: While `read_keys_o`=1, data bytes leave the memory and `addr_o` unchanged.
- R12: Memory byte i appears on `mem_o[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stb_i | input | 1 | Serial strobe, frame active low |
| sclk_i | input | 1 | Serial shift clock |
| dio_i | input | 1 | Serial data in |
| byte_stb_o | output | 1 | One-cycle pulse per received byte |
| grid5_o | output | 1 | Layout: 1 = 5 grids/7 segments, 0 = 4 grids/8 segments |
| test_mode_o | output | 1 | Test mode flag |
| fixed_addr_o | output | 1 | Address held after writes |
| read_keys_o | output | 1 | Read-keys transfer selected |
| disp_on_o | output | 1 | Display enable |
| dim_o | output | 3 | Dimming code |
| addr_o | output | 4 | Current memory pointer |
| mem_o | output | 112 | Display memory, byte i at bits 8i+7:8i |

## Verification
A corrupted shift register or bit counter would show up within a single frame. Every configuration output and every memory byte can be seen at the ports, so a byte misaligned by one bit would land as a wrong command class or in the wrong memory slot and be visible a few cycles after `stb_i` rises. A stale first-byte flag would let a data byte be decoded as a command, or the reverse, and that changes `addr_o` or the configuration on the very next byte. Pointer faults around the 0x0D/0x0E boundary would show as a wrong `addr_o`, or as a memory byte that changed when it should not have, right after the frame that crosses the boundary.

// File: rtl/dsp_cmd_pkg.sv
package dsp_cmd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_DATA = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_ADDR = 2'b11
  } cmd_cls_e;
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/dsp_rx.sv
module dsp_rx
  import dsp_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_s_i,
  input  logic              sclk_s_i,
  input  logic              dio_s_i,
  output logic              vld_o,
  output logic              is_cmd_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_q;
  logic              rise;
  logic [CNT_W-1:0]  cnt_q;
  logic              first_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_nxt;

  assign rise   = sclk_s_i & ~sclk_q;
  assign sh_nxt = {dio_s_i, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      first_q  <= 1'b1;
      sh_q     <= '0;
      vld_o    <= 1'b0;
      is_cmd_o <= 1'b0;
      data_o   <= '0;
    end else if (stb_s_i) begin
      // idle or aborted frame: drop partial bits, next byte is a command
      cnt_q   <= '0;
      first_q <= 1'b1;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (rise) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          vld_o    <= 1'b1;
          data_o   <= sh_nxt;
          is_cmd_o <= first_q;
          first_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dsp_regs.sv
module dsp_regs
  import dsp_cmd_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 14,
  parameter int unsigned AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              is_cmd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              grid5_o,
  output logic              test_mode_o,
  output logic              fixed_addr_o,
  output logic              read_keys_o,
  output logic              disp_on_o,
  output logic [2:0]        dim_o,
  output logic [AW-1:0]     addr_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(MEM_BYTES - 1);

  cmd_cls_e cls;
  logic     addr_ok;
  logic     unused_bits;

  assign cls         = cmd_cls_e'(data_i[7:6]);
  assign addr_ok     = (addr_o <= LAST_ADDR);
  assign unused_bits = ^data_i[5:4];

  assign we_o    = vld_i & ~is_cmd_i & ~read_keys_o & addr_ok;
  assign waddr_o = addr_o;
  assign wdata_o = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grid5_o      <= 1'b0;
      test_mode_o  <= 1'b0;
      fixed_addr_o <= 1'b0;
      read_keys_o  <= 1'b0;
      disp_on_o    <= 1'b0;
      dim_o        <= '0;
      addr_o       <= '0;
    end else if (vld_i && is_cmd_i) begin
      unique case (cls)
        CLS_MODE: begin
          if (data_i[1] == 1'b0 && data_i[0] != grid5_o) begin
            grid5_o   <= data_i[0];
            disp_on_o <= 1'b0;
          end
        end
        CLS_DATA: begin
          test_mode_o  <= data_i[3];
          fixed_addr_o <= data_i[2];
          read_keys_o  <= data_i[1];
        end
        CLS_CTRL: begin
          disp_on_o <= data_i[3];
          dim_o     <= data_i[2:0];
        end
        CLS_ADDR: addr_o <= data_i[AW-1:0];
        default: ;
      endcase
    end else if (we_o && !fixed_addr_o) begin
      addr_o <= addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/dsp_mem.sv
module dsp_mem
  import dsp_cmd_pkg::*;
#(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned AW = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  output logic [DEPTH*BYTE_W-1:0] mem_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [BYTE_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ent_q <= '0;
      else if (we_i && waddr_i == AW'(g))     ent_q <= wdata_i;
    end
    assign mem_o[g*BYTE_W +: BYTE_W] = ent_q;
  end
endmodule

// File: rtl/dsp_cmd_if.sv
module dsp_cmd_if
  import dsp_cmd_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 14,
  localparam int unsigned AW = 4,
  localparam int unsigned MW = MEM_BYTES * BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic          sclk_i,
  input  logic          dio_i,
  output logic          byte_stb_o,
  output logic          grid5_o,
  output logic          test_mode_o,
  output logic          fixed_addr_o,
  output logic          read_keys_o,
  output logic          disp_on_o,
  output logic [2:0]    dim_o,
  output logic [AW-1:0] addr_o,
  output logic [MW-1:0] mem_o
);
  logic [2:0]        pins_s;
  logic              vld, is_cmd, we;
  logic [BYTE_W-1:0] rx_data, wdata;
  logic [AW-1:0]     waddr;

  dsp_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dio_i, sclk_i, stb_i}),
    .q_o   (pins_s)
  );

  dsp_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_s_i (pins_s[0]),
    .sclk_s_i(pins_s[1]),
    .dio_s_i (pins_s[2]),
    .vld_o   (vld),
    .is_cmd_o(is_cmd),
    .data_o  (rx_data)
  );

  dsp_regs #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vld_i       (vld),
    .is_cmd_i    (is_cmd),
    .data_i      (rx_data),
    .grid5_o     (grid5_o),
    .test_mode_o (test_mode_o),
    .fixed_addr_o(fixed_addr_o),
    .read_keys_o (read_keys_o),
    .disp_on_o   (disp_on_o),
    .dim_o       (dim_o),
    .addr_o      (addr_o),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata)
  );

  dsp_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .mem_o  (mem_o)
  );

  assign byte_stb_o = vld;
endmodule

// File: rtl/dsp_cmd_if_chk.sv
module dsp_cmd_if_chk #(
  parameter int unsigned MEM_BYTES = 14,
  localparam int unsigned MW = MEM_BYTES * 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stb_i,
  input logic          sclk_i,
  input logic          dio_i,
  input logic          byte_stb_o,
  input logic          grid5_o,
  input logic          test_mode_o,
  input logic          fixed_addr_o,
  input logic          read_keys_o,
  input logic          disp_on_o,
  input logic [2:0]    dim_o,
  input logic [3:0]    addr_o,
  input logic [MW-1:0] mem_o
);
  // a byte needs eight serial edges, so pulses never touch
  p_single_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |=> !byte_stb_o);

  // state moves only in the cycle after a received byte
  p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(byte_stb_o) |-> ($stable(mem_o) && $stable(addr_o) && $stable(disp_on_o)
                            && $stable(dim_o) && $stable(grid5_o) && $stable(test_mode_o)
                            && $stable(fixed_addr_o) && $stable(read_keys_o)));

  p_mode_change_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grid5_o != $past(grid5_o)) |-> !disp_on_o);

  p_no_write_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(addr_o) > 4'(MEM_BYTES - 1)) |-> $stable(mem_o));

  p_no_write_read_keys_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(read_keys_o) && read_keys_o) |-> $stable(mem_o));
endmodule

bind dsp_cmd_if dsp_cmd_if_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (.*);

// File: tb/dsp_cmd_if_test.sv
module dsp_cmd_if_test;
  localparam int NB = 14;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stb = 1'b1, sclk = 1'b1, dio = 1'b1;
  logic byte_stb, grid5, test_mode, fixed_addr, read_keys, disp_on;
  logic [2:0] dim;
  logic [3:0] addr;
  logic [NB*8-1:0] mem;

  int checks = 0, fails = 0, pulses = 0, sent = 0;

  // expected state
  logic e_grid5, e_test, e_fixed, e_rd, e_on;
  logic [2:0] e_dim;
  logic [3:0] e_addr;
  logic [7:0] e_mem [NB];

  always #10 clk = ~clk;

  dsp_cmd_if uut (
    .clk_i(clk), .rst_ni(rst_ni), .stb_i(stb), .sclk_i(sclk), .dio_i(dio),
    .byte_stb_o(byte_stb), .grid5_o(grid5), .test_mode_o(test_mode),
    .fixed_addr_o(fixed_addr), .read_keys_o(read_keys), .disp_on_o(disp_on),
    .dim_o(dim), .addr_o(addr), .mem_o(mem)
  );

  always @(negedge clk) if (rst_ni && byte_stb) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic mdl_reset();
    e_grid5 = 0; e_test = 0; e_fixed = 0; e_rd = 0; e_on = 0; e_dim = 0; e_addr = 0;
    for (int i = 0; i < NB; i++) e_mem[i] = 8'h00;
  endtask

  task automatic mdl_byte(input logic [7:0] b, input bit is_cmd);
    if (is_cmd) begin
      case (b[7:6])
        2'b00: if (!b[1] && b[0] != e_grid5) begin e_grid5 = b[0]; e_on = 0; end
        2'b01: begin e_test = b[3]; e_fixed = b[2]; e_rd = b[1]; end
        2'b10: begin e_on = b[3]; e_dim = b[2:0]; end
        default: e_addr = b[3:0];
      endcase
    end else if (!e_rd && e_addr < NB) begin
      e_mem[e_addr] = b;
      if (!e_fixed) e_addr = e_addr + 1;
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; dio = b[i];
      tick(3);
      sclk = 1'b1;
      tick(3);
    end
  endtask

  task automatic frame(input logic [7:0] bytes [8], input int n);
    stb = 1'b0; tick(4);
    for (int k = 0; k < n; k++) begin
      send_bits(bytes[k], 8);
      sent++;
      mdl_byte(bytes[k], k == 0);
    end
    tick(2); stb = 1'b1; dio = 1'b1; tick(8);
  endtask

  task automatic cmp_all(input string req);
    chk({req, " grid5"}, 32'(grid5), 32'(e_grid5));
    chk({req, " test"}, 32'(test_mode), 32'(e_test));
    chk({req, " fixed"}, 32'(fixed_addr), 32'(e_fixed));
    chk({req, " rdkeys"}, 32'(read_keys), 32'(e_rd));
    chk({req, " on"}, 32'(disp_on), 32'(e_on));
    chk({req, " dim"}, 32'(dim), 32'(e_dim));
    chk({req, " addr"}, 32'(addr), 32'(e_addr));
    for (int i = 0; i < NB; i++) chk({req, " R12 mem"}, 32'(mem[8*i +: 8]), 32'(e_mem[i]));
  endtask

  initial begin : watchdog
    #3_900_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] f [8];
    void'($urandom(32'h5eed));
    mdl_reset();
    tick(3); rst_ni = 1'b1; tick(3);
    cmp_all("R10 reset");

    // R1 R9: LSB first, display control 0x8D -> on, dim 5
    f[0] = 8'h8D; frame(f, 1); cmp_all("R1 R9 ctrl");
    // R5: change layout clears display, resend same is no-op
    f[0] = 8'h01; frame(f, 1); cmp_all("R5 change");
    chk("R5 off after change", 32'(disp_on), 0);
    f[0] = 8'h8F; frame(f, 1);
    f[0] = 8'h3D; frame(f, 1); cmp_all("R5 same mode");
    chk("R5 still on", 32'(disp_on), 1);
    // R7 R8: increment through 0x0D into 0x0E, then drop
    f[0] = 8'hCC; f[1] = 8'hA1; f[2] = 8'hB2; f[3] = 8'hC3; frame(f, 4);
    cmp_all("R7 R8 boundary");
    chk("R8 end addr", 32'(addr), 32'h0E);
    // R8 fixed address, R4 bits 5:4 ignored
    f[0] = 8'h74; frame(f, 1);
    f[0] = 8'hF3; f[1] = 8'h11; f[2] = 8'h22; frame(f, 3); cmp_all("R8 fixed R4");
    // R11 read-keys: writes blocked
    f[0] = 8'h42; frame(f, 1);
    f[0] = 8'hC0; f[1] = 8'h99; frame(f, 2); cmp_all("R11 rdkeys");
    f[0] = 8'h40; frame(f, 1);
    // R2: clock toggles with strobe high
    for (int i = 0; i < 16; i++) begin sclk = 1'b0; dio = i[0]; tick(3); sclk = 1'b1; tick(3); end
    cmp_all("R2 stb high");
    // R3: abort after 5 bits, next frame's first byte is a command
    stb = 1'b0; tick(4); send_bits(8'h8A, 5); stb = 1'b1; tick(8);
    cmp_all("R3 abort");
    f[0] = 8'hC3; f[1] = 8'h5A; frame(f, 2); cmp_all("R3 after abort");

    // random frames
    for (int t = 0; t < 260; t++) begin
      int n;
      n = 1 + int'($urandom_range(0, 3));
      for (int k = 0; k < n; k++) f[k] = 8'($urandom);
      if ($urandom_range(0, 3) == 0) f[0][7:6] = 2'b11;
      if (f[0][7:6] == 2'b01 && $urandom_range(0, 2) != 0) f[0][1] = 1'b0;
      frame(f, n);
      cmp_all("R4 R6 random");
    end
    chk("R1 pulse count", 32'(pulses), 32'(sent));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule